// File: doc/BRIEF.md
# DAC Output Mode Sequencer

This block decides, for each channel of a multi-channel DAC, which code reaches the converter, whether the channel is reported as muted, and whether its output buffer is driven. It holds the working copy of each channel code and of the mode-control byte. Writes from the register interface update that copy. A software mute forces a channel to its low-reference level (code 0 relative to that reference), and the stored code is kept. A software power-down releases the output buffer. An active-low external pin mutes every channel at once.

After power-on reset the block copies the persistent codes and the persistent mode byte into the working registers on the first clock. It then holds every output muted for a programmable initialization window before the loaded values take effect. Register writes never change the mode. A code written while a channel is muted or powered down only becomes visible when that mode is left.

Top module: `dac_out_sequencer`

## Requirements
- R1: On the first clock edge after reset release, the working codes take `nv_code_i` and the working mode byte takes `nv_mode_i`. Once initialization ends, these values are what the outputs show.
- R2: From reset until `INIT_CYCLES`+1 clock edges after reset release, `init_busy_o` is 1. During that window every `muted_o` bit is 1, every effective code is 0 and every `oe_o` bit is 1. Writes presented in that window are ignored.
- R3: In the mode byte, bit 4 mutes channel 0, bit 5 mutes channel 1, bit 0 powers down channel 0 and bit 1 powers down channel 1. Bits 2, 3, 6 and 7 have no effect on any output.
- R4: A software-muted channel presents effective code 0 and `muted_o`=1. When the mute is cleared, the channel shows its stored working code again.
- R5: A powered-down channel has `oe_o`=0, including when it is also muted. Power-down takes priority for the output enable.
- R6: While `mute_ni` is low, every effective code is 0 in the same cycle, with no clock edge needed. `muted_o` follows the pin through a two-flop synchronizer: it reflects a pin change two clock edges later.
- R7: A code write never changes the mode. A code written while its channel is muted or powered down appears on the output only once that mode is cleared.
- R8: After initialization, a code or mode write presented before a clock edge affects the outputs right after that edge.
- R9: With a persistent mode byte of 00 hex, every channel comes out of initialization unmuted and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| nv_code_i | input | NCH*CODE_W | Persistent channel codes, channel 0 in the low bits |
| nv_mode_i | input | 8 | Persistent mode-control byte |
| code_wr_i | input | NCH | Per-channel working code write strobe |
| code_wdata_i | input | CODE_W | Code write data |
| mode_wr_i | input | 1 | Working mode byte write strobe |
| mode_wdata_i | input | 8 | Mode byte write data |
| mute_ni | input | 1 | Active-low external mute pin, asynchronous |
| eff_code_o | output | NCH*CODE_W | Effective code per channel |
| muted_o | output | NCH | Channel muted flag |
| oe_o | output | NCH | Output buffer enable per channel |
| init_busy_o | output | 1 | Initialization window active |

## Verification
Code and mode writes are due one edge after the strobe, so the expected state is advanced at each rising edge and compared at the following falling edge. The pin's forcing of the codes is due in the same cycle, so the bench drives the pin just after an edge and checks before the next one. The muted flag is due two edges after a pin change, and `init_busy_o` drops after exactly `INIT_CYCLES`+1 edges from reset release. The bench model counts these edges itself and compares every output on every cycle. Named spot checks cover reset, the load, the bit map, priority and the pin lag.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int MODE_W   = 8;
  localparam int MUTE_LSB = 4;  // mute bits sit above power-down bits
  localparam int MAX_CH   = 4;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seq_sync2.sv
module seq_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/seq_init_ctrl.sv
module seq_init_ctrl
  import dac_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic run_o
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

  seq_state_e  state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          state_q <= ST_HOLD;
          cnt_q   <= '0;
        end
        ST_HOLD: begin
          if (cnt_q == CNT_LAST) state_q <= ST_RUN;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign load_o = (state_q == ST_LOAD);
  assign run_o  = (state_q == ST_RUN);

  a_r2_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
  a_r1_load_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o && !run_o);
endmodule

// File: rtl/seq_chan_out.sv
module seq_chan_out #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              sw_mute_i,
  input  logic              pd_i,
  input  logic              busy_i,
  input  logic              pin_raw_ni,
  input  logic              pin_sync_ni,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              muted_o,
  output logic              oe_o
);
  logic force_low;

  // raw pin gates the code path so the mute needs no clock
  assign force_low  = busy_i | sw_mute_i | ~pin_raw_ni;
  assign eff_code_o = force_low ? '0 : code_i;
  assign muted_o    = busy_i | sw_mute_i | ~pin_sync_ni;
  // during init the buffer drives the low reference; power-down wins after
  assign oe_o       = busy_i | ~pd_i;
endmodule

// File: rtl/dac_out_sequencer.sv
module dac_out_sequencer
  import dac_seq_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int CODE_W      = 8,
  parameter int INIT_CYCLES = 125000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH*CODE_W-1:0] nv_code_i,
  input  logic [MODE_W-1:0]     nv_mode_i,
  input  logic [NCH-1:0]        code_wr_i,
  input  logic [CODE_W-1:0]     code_wdata_i,
  input  logic                  mode_wr_i,
  input  logic [MODE_W-1:0]     mode_wdata_i,
  input  logic                  mute_ni,
  output logic [NCH*CODE_W-1:0] eff_code_o,
  output logic [NCH-1:0]        muted_o,
  output logic [NCH-1:0]        oe_o,
  output logic                  init_busy_o
);
  logic load, run, pin_sync_n;
  logic [MODE_W-1:0]                mode_q;
  logic [NCH-1:0][CODE_W-1:0]       code_q;

  seq_init_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_o (load),
    .run_o  (run)
  );

  seq_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mute_ni),
    .q_o    (pin_sync_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      code_q <= '0;
    end else if (load) begin
      mode_q <= nv_mode_i;
      code_q <= nv_code_i;
    end else if (run) begin
      if (mode_wr_i) mode_q <= mode_wdata_i;
      for (int c = 0; c < NCH; c++) begin
        if (code_wr_i[c]) code_q[c] <= code_wdata_i;
      end
    end
  end

  assign init_busy_o = ~run;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    seq_chan_out #(.CODE_W(CODE_W)) u_ch (
      .code_i      (code_q[c]),
      .sw_mute_i   (mode_q[MUTE_LSB+c]),
      .pd_i        (mode_q[c]),
      .busy_i      (~run),
      .pin_raw_ni  (mute_ni),
      .pin_sync_ni (pin_sync_n),
      .eff_code_o  (eff_code_o[c*CODE_W +: CODE_W]),
      .muted_o     (muted_o[c]),
      .oe_o        (oe_o[c])
    );

    a_r5_pd_drops_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run && mode_q[c] |-> !oe_o[c]);
    a_r4_mute_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q[MUTE_LSB+c] |-> muted_o[c] && eff_code_o[c*CODE_W +: CODE_W] == '0);
  end

  a_r1_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> code_q == $past(nv_code_i) && mode_q == $past(nv_mode_i));
  a_r2_busy_all_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_busy_o |-> (&muted_o) && (&oe_o) && eff_code_o == '0);
  a_r6_pin_forces_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_ni |-> eff_code_o == '0);
  a_r7_code_wr_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load && !mode_wr_i |=> $stable(mode_q));
  a_r2_no_write_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load && !run |=> $stable(code_q));
endmodule

// File: tb/dac_out_sequencer_tb_top.sv
module dac_out_sequencer_tb_top;
  localparam int NCH  = 2;
  localparam int CW   = 8;
  localparam int INIT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   nv_code = 16'hC35A;
  logic [7:0]    nv_mode = 8'h00;
  logic [1:0]    code_wr = '0;
  logic [7:0]    code_wdata = '0;
  logic          mode_wr = 1'b0;
  logic [7:0]    mode_wdata = '0;
  logic          mute_n = 1'b1;
  logic [15:0]   eff_code;
  logic [1:0]    muted, oe;
  logic          busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_out_sequencer #(.NCH(NCH), .CODE_W(CW), .INIT_CYCLES(INIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nv_code_i(nv_code), .nv_mode_i(nv_mode),
    .code_wr_i(code_wr), .code_wdata_i(code_wdata), .mode_wr_i(mode_wr),
    .mode_wdata_i(mode_wdata), .mute_ni(mute_n), .eff_code_o(eff_code),
    .muted_o(muted), .oe_o(oe), .init_busy_o(busy)
  );

  // behavioural reference: edges since reset, working state, pin history
  int       m_cyc;
  logic [7:0] m_mode;
  logic [7:0] m_code [2];
  logic     m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_mode = 8'h00; m_code[0] = 8'h00; m_code[1] = 8'h00;
      m_s1 = 1'b1; m_s2 = 1'b1;
    end else begin
      if (m_cyc == 0) begin
        m_mode = nv_mode; m_code[0] = nv_code[7:0]; m_code[1] = nv_code[15:8];
      end else if (m_cyc >= INIT + 1) begin
        if (mode_wr) m_mode = mode_wdata;
        for (int c = 0; c < NCH; c++) if (code_wr[c]) m_code[c] = code_wdata;
      end
      m_s2 = m_s1;
      m_s1 = mute_n;
      if (m_cyc < 1000000) m_cyc++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit m_busy;
      m_busy = !(m_cyc >= INIT + 1);
      chk("R2 busy", {31'd0, busy}, {31'd0, m_busy});
      for (int c = 0; c < NCH; c++) begin
        logic mt, pd, e_mut, e_oe;
        logic [7:0] e_code;
        mt = m_mode[4+c]; pd = m_mode[c];
        e_code = (m_busy || mt || !mute_n) ? 8'h00 : m_code[c];
        e_mut  = m_busy || mt || !m_s2;
        e_oe   = m_busy || !pd;
        if (!mute_n)     chk("R6 code", {24'd0, eff_code[c*8 +: 8]}, {24'd0, e_code});
        else if (mt)     chk("R4 code", {24'd0, eff_code[c*8 +: 8]}, {24'd0, e_code});
        else             chk("R8 code", {24'd0, eff_code[c*8 +: 8]}, {24'd0, e_code});
        chk("R3 muted", {31'd0, muted[c]}, {31'd0, e_mut});
        chk("R5 oe", {31'd0, oe[c]}, {31'd0, e_oe});
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr_code(int c, logic [7:0] v);
    code_wr[c] = 1'b1; code_wdata = v;
    step(); code_wr = '0;
  endtask

  task automatic wr_mode(logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    step(); mode_wr = 1'b0;
  endtask

  task automatic spot(string tag, logic [31:0] act, logic [31:0] exp);
    @(negedge clk); #0.5;
    chk(tag, act, exp);
  endtask

  initial begin
    step(3);
    // reset state
    @(negedge clk); #0.5;
    chk("R2 reset busy", {31'd0, busy}, 32'd1);
    chk("R2 reset oe", {30'd0, oe}, 32'd3);
    chk("R2 reset code", {16'd0, eff_code}, 32'd0);
    step();
    rst_n = 1'b1;
    step(3);
    wr_code(0, 8'h11);   // inside init window: ignored
    step(INIT + 2);
    @(negedge clk); #0.5;
    chk("R1 loaded codes", {16'd0, eff_code}, 32'h0000C35A);
    chk("R9 unmuted", {30'd0, muted}, 32'd0);
    chk("R9 enabled", {30'd0, oe}, 32'd3);
    chk("R2 init write ignored", {24'd0, eff_code[7:0]}, 32'h5A);
    step();
    wr_code(1, 8'hA5);
    @(negedge clk); #0.5;
    chk("R8 write next edge", {24'd0, eff_code[15:8]}, 32'hA5);
    step();
    wr_mode(8'h10);
    @(negedge clk); #0.5;
    chk("R3 bit4 mutes ch0", {16'd0, eff_code}, 32'h0000A500);
    chk("R3 ch0 flag", {30'd0, muted}, 32'd1);
    step();
    wr_code(0, 8'h77);
    @(negedge clk); #0.5;
    chk("R7 muted write hidden", {24'd0, eff_code[7:0]}, 32'h00);
    chk("R7 mode unchanged", {30'd0, muted}, 32'd1);
    step();
    wr_mode(8'h00);
    @(negedge clk); #0.5;
    chk("R4 R7 unmute shows code", {24'd0, eff_code[7:0]}, 32'h77);
    step();
    wr_mode(8'hCC);
    @(negedge clk); #0.5;
    chk("R3 ignored bits code", {16'd0, eff_code}, 32'h0000A577);
    chk("R3 ignored bits oe", {30'd0, oe}, 32'd3);
    chk("R3 ignored bits muted", {30'd0, muted}, 32'd0);
    step();
    wr_mode(8'h02);
    @(negedge clk); #0.5;
    chk("R5 pd ch1", {30'd0, oe}, 32'd1);
    step();
    wr_code(1, 8'h3C);
    wr_mode(8'h23);
    @(negedge clk); #0.5;
    chk("R5 pd over mute", {30'd0, oe}, 32'd0);
    chk("R4 ch1 muted", {30'd0, muted}, 32'd2);
    step();
    wr_mode(8'h00);
    @(negedge clk); #0.5;
    chk("R7 pd exit code", {16'd0, eff_code}, 32'h00003C77);
    step();
    mute_n = 1'b0;
    @(negedge clk); #0.5;
    chk("R6 immediate zero", {16'd0, eff_code}, 32'd0);
    chk("R6 flag lag 0", {30'd0, muted}, 32'd0);
    step();
    @(negedge clk); #0.5;
    chk("R6 flag lag 1", {30'd0, muted}, 32'd0);
    step();
    @(negedge clk); #0.5;
    chk("R6 flag after 2", {30'd0, muted}, 32'd3);
    step();
    mute_n = 1'b1;
    step(3);
    @(negedge clk); #0.5;
    chk("R6 release", {16'd0, eff_code}, 32'h00003C77);
    // second power-on with a stored mode
    step();
    rst_n = 1'b0; nv_mode = 8'h31; nv_code = 16'h8001;
    step(2);
    rst_n = 1'b1;
    step(INIT + 3);
    @(negedge clk); #0.5;
    chk("R1 mode loaded muted", {30'd0, muted}, 32'd3);
    chk("R1 mode loaded pd", {30'd0, oe}, 32'd2);
    step();
    wr_mode(8'h00);
    @(negedge clk); #0.5;
    chk("R1 codes loaded", {16'd0, eff_code}, 32'h00008001);
    step(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule